// File: doc/BRIEF.md
# Quarter-Wave Notch Pattern Gate Generator

This block drives the four switches of a single-phase full-bridge voltage-source inverter with a three-level waveform whose switching instants are programmed to cancel chosen low-order odd harmonics. A table of N switching points covers one quarter of the output period. Each point is a count of a 16-bit phase accumulator, which advances by a programmable step every clock. With N points, N−1 odd harmonics can be nulled: the 3rd, the 5th, and so on. Within the first quarter the output toggles between zero and full level at each stored point. The second quarter replays the points mirrored about the quarter peak. The second half repeats the first half with the opposite polarity.

Each target level (positive, negative or zero) is decoded into one gate state for the two legs. In every state exactly one switch per leg conducts, so a short across the supply or an undefined all-off bridge is never commanded. The two zero states (both upper switches, or both lower switches) are taken in turn at successive zero intervals, which spreads conduction between them.

Tables arrive as a valid/ready stream of N angle beats, with the final beat marked. A table is checked on its final beat. If it is well formed, it waits and replaces the running table at the next period wrap. If it is malformed, it is discarded and an error flag is raised. While a checked table waits for the wrap, ready is held low. This back-pressures the stream, and a beat offered during that time stays on the inputs until ready returns. Beats are taken on any edge where valid and ready are both high. Dead time, angle computation and analog drive lie outside the block.

Top module: `sheg_gate_gen`

## Requirements
- R1: The phase advances by `freq_i` modulo 2^16 on every clock. An output period ends on the edge where the addition carries out of bit 15, and each quarter spans 0x4000 counts.
- R2: In the first quarter (phase bits 15:14 = 00), let x be the offset in bits 13:0. The level is positive when an odd number of the stored angles are less than or equal to x, and zero otherwise.
- R3: In the second quarter (bits 15:14 = 01), the same rule applies with x replaced by 0x4000 minus the offset, which mirrors the first quarter.
- R4: In the second half (bit 15 = 1), the level is the first-half level with the polarity reversed: positive becomes negative, and zero stays zero.
- R5: Gate states are written {leg1_hi, leg1_lo, leg2_hi, leg2_lo}. Positive drives 1001 and negative drives 0110. The gate outputs are registered, and they reflect the phase value held during the cycle before the edge.
- R6: A zero level drives 0101 (both lower switches) or 1010 (both upper switches). Reset selects 0101, and each new zero interval that follows a non-zero level flips the selection.
- R7: On every cycle, exactly one of the two switches of each leg is on.
- R8: A table is accepted only when exactly N beats arrive with `ld_last_i` on the Nth, every angle is below 0x4000, and the angles strictly increase in beat order. Any other table sets `tbl_err_o` and leaves the running pattern unchanged. An accepted table clears `tbl_err_o`.
- R9: An accepted table takes effect on the first period wrap after its final beat. Until that wrap, `ld_ready_o` is low.
- R10: Until the first table takes effect, the level is zero.
- R11: During reset, the outputs are gates 0101, `ld_ready_o` high and `tbl_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_i | input | 16 | Phase step per clock |
| ld_valid_i | input | 1 | Angle beat valid |
| ld_ready_o | output | 1 | Block can take an angle beat |
| ld_angle_i | input | 16 | Angle in phase counts |
| ld_last_i | input | 1 | Marks the final beat of a table |
| tbl_err_o | output | 1 | Last table offered was malformed |
| leg1_hi_o | output | 1 | Leg 1 upper switch gate |
| leg1_lo_o | output | 1 | Leg 1 lower switch gate |
| leg2_hi_o | output | 1 | Leg 2 upper switch gate |
| leg2_lo_o | output | 1 | Leg 2 lower switch gate |

## Verification
The pattern is exercised with no table loaded, then with two angle sets of different spacing. One of these sets has a point one count below the quarter edge, which separates the mirror arithmetic of the second quarter from a plain reuse of the offset. Step sizes of 0x100, 0x333, 0x040, zero and 0xFFFF are used. They separate correct quarter and wrap detection from off-by-one boundaries, and they show that a stalled or nearly reversed phase still gives legal gate states. Malformed tables of each kind (out of order, equal neighbours, an angle at the quarter edge, too short, too long) confirm that only the error flag moves. A second table offered back to back while the first is still waiting shows the back-pressure, and shows that each swap lands on a period wrap.

// File: rtl/sheg_pkg.sv
package sheg_pkg;
  typedef enum logic [1:0] {
    LVL_ZERO = 2'd0,
    LVL_POS  = 2'd1,
    LVL_NEG  = 2'd2
  } level_e;

  // Gate vectors ordered {leg1_hi, leg1_lo, leg2_hi, leg2_lo}
  localparam logic [3:0] GATES_POS  = 4'b1001;
  localparam logic [3:0] GATES_NEG  = 4'b0110;
  localparam logic [3:0] GATES_ZTOP = 4'b1010;
  localparam logic [3:0] GATES_ZBOT = 4'b0101;
endpackage

// File: rtl/sheg_phase_acc.sv
module sheg_phase_acc #(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq,
  output logic [PHASE_W-1:0] phase,
  output logic               wrap
);
  logic [PHASE_W:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, freq};
  assign wrap = sum[PHASE_W];  // carry marks the start of a new period

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= sum[PHASE_W-1:0];
  end
endmodule

// File: rtl/sheg_angle_table.sv
module sheg_angle_table #(
  parameter int PHASE_W = 16,
  parameter int N_ANG   = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_valid,
  output logic                            ld_ready,
  input  logic [PHASE_W-1:0]              ld_angle,
  input  logic                            ld_last,
  input  logic                            wrap,
  output logic                            tbl_err,
  output logic                            pending,
  output logic                            act_valid,
  output logic [N_ANG-1:0][PHASE_W-1:0]   active
);
  localparam int               IDX_W    = $clog2(N_ANG + 1);
  localparam logic [PHASE_W-1:0] QTR    = PHASE_W'(1) << (PHASE_W - 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ANG - 1);
  localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(N_ANG);

  logic [N_ANG-1:0][PHASE_W-1:0] shadow, shadow_nx;
  logic [IDX_W-1:0]              widx;
  logic                          ovf;
  logic [N_ANG-1:0]              ok_k;
  logic                          accept, good;

  assign ld_ready = !pending;
  assign accept   = ld_valid && ld_ready;

  always_comb begin
    shadow_nx = shadow;
    for (int k = 0; k < N_ANG; k++) begin
      if (accept && widx == IDX_W'(k)) shadow_nx[k] = ld_angle;
    end
  end

  // Ordering and range check over the table as it stands after this beat
  for (genvar k = 0; k < N_ANG; k++) begin : g_ord
    if (k == 0) begin : g_first
      assign ok_k[k] = shadow_nx[k] < QTR;
    end else begin : g_rest
      assign ok_k[k] = (shadow_nx[k] < QTR) && (shadow_nx[k-1] < shadow_nx[k]);
    end
  end

  assign good = (&ok_k) && !ovf && (widx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow    <= '0;
      active    <= '0;
      widx      <= '0;
      ovf       <= 1'b0;
      pending   <= 1'b0;
      act_valid <= 1'b0;
      tbl_err   <= 1'b0;
    end else begin
      if (wrap && pending) begin
        active    <= shadow;
        act_valid <= 1'b1;
        pending   <= 1'b0;
      end
      if (accept) begin
        shadow <= shadow_nx;
        if (ld_last) begin
          widx <= '0;
          ovf  <= 1'b0;
          if (good) begin
            pending <= 1'b1;
            tbl_err <= 1'b0;
          end else begin
            tbl_err <= 1'b1;
          end
        end else if (widx == FULL_IDX) begin
          ovf <= 1'b1;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sheg_level.sv
module sheg_level
  import sheg_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int N_ANG   = 5
) (
  input  logic [PHASE_W-1:0]            phase,
  input  logic                          act_valid,
  input  logic [N_ANG-1:0][PHASE_W-1:0] active,
  output level_e                        level
);
  localparam logic [PHASE_W-1:0] QTR = PHASE_W'(1) << (PHASE_W - 2);

  logic [PHASE_W-1:0] off, pos;
  logic [N_ANG-1:0]   hits;

  assign off = {2'b00, phase[PHASE_W-3:0]};
  // Odd quarters run the stored points backwards from the quarter edge
  assign pos = phase[PHASE_W-2] ? (QTR - off) : off;

  for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
    assign hits[k] = active[k] <= pos;
  end

  always_comb begin
    if (!act_valid || !(^hits)) level = LVL_ZERO;
    else if (phase[PHASE_W-1])  level = LVL_NEG;
    else                        level = LVL_POS;
  end
endmodule

// File: rtl/sheg_gate_map.sv
module sheg_gate_map
  import sheg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  level_e     level,
  output logic [3:0] gates
);
  level_e     lvl_q;
  logic       zsel_q, zsel_nx;
  logic [3:0] gates_nx;

  // Flip the zero-state choice on every entry into a zero interval
  assign zsel_nx = (level == LVL_ZERO && lvl_q != LVL_ZERO) ? ~zsel_q : zsel_q;

  always_comb begin
    case (level)
      LVL_POS: gates_nx = GATES_POS;
      LVL_NEG: gates_nx = GATES_NEG;
      default: gates_nx = zsel_nx ? GATES_ZTOP : GATES_ZBOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_ZERO;
      zsel_q <= 1'b0;
      gates  <= GATES_ZBOT;
    end else begin
      lvl_q  <= level;
      zsel_q <= zsel_nx;
      gates  <= gates_nx;
    end
  end
endmodule

// File: rtl/sheg_gate_gen.sv
module sheg_gate_gen
  import sheg_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int N_ANG   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] freq_i,
  input  logic               ld_valid_i,
  output logic               ld_ready_o,
  input  logic [PHASE_W-1:0] ld_angle_i,
  input  logic               ld_last_i,
  output logic               tbl_err_o,
  output logic               leg1_hi_o,
  output logic               leg1_lo_o,
  output logic               leg2_hi_o,
  output logic               leg2_lo_o
);
  logic [PHASE_W-1:0]            phase;
  logic                          wrap;
  logic                          pending;
  logic                          act_valid;
  logic [N_ANG-1:0][PHASE_W-1:0] active_tbl;
  level_e                        level;
  logic [3:0]                    gates;

  sheg_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .freq  (freq_i),
    .phase (phase),
    .wrap  (wrap)
  );

  sheg_angle_table #(.PHASE_W(PHASE_W), .N_ANG(N_ANG)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid_i),
    .ld_ready  (ld_ready_o),
    .ld_angle  (ld_angle_i),
    .ld_last   (ld_last_i),
    .wrap      (wrap),
    .tbl_err   (tbl_err_o),
    .pending   (pending),
    .act_valid (act_valid),
    .active    (active_tbl)
  );

  sheg_level #(.PHASE_W(PHASE_W), .N_ANG(N_ANG)) u_lvl (
    .phase     (phase),
    .act_valid (act_valid),
    .active    (active_tbl),
    .level     (level)
  );

  sheg_gate_map u_map (
    .clk   (clk),
    .rst_n (rst_n),
    .level (level),
    .gates (gates)
  );

  assign {leg1_hi_o, leg1_lo_o, leg2_hi_o, leg2_lo_o} = gates;
endmodule

// File: rtl/sheg_gate_gen_chk.sv
module sheg_gate_gen_chk #(
  parameter int PHASE_W = 16,
  parameter int N_ANG   = 5
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          leg1_hi,
  input logic                          leg1_lo,
  input logic                          leg2_hi,
  input logic                          leg2_lo,
  input logic                          ld_valid,
  input logic                          ld_ready,
  input logic                          ld_last,
  input logic                          tbl_err,
  input logic                          wrap,
  input logic                          pending,
  input logic                          act_valid,
  input logic [N_ANG-1:0][PHASE_W-1:0] active
);
  assert_leg1_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({leg1_hi, leg1_lo}) == 1);

  assert_leg2_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({leg2_hi, leg2_lo}) == 1);

  assert_err_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_err) |-> $past(ld_valid && ld_ready && ld_last));

  assert_swap_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(wrap));

  assert_table_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> $stable(active));

  assert_zero_without_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid |=> (leg1_hi == leg2_hi && leg1_lo == leg2_lo));
endmodule

bind sheg_gate_gen sheg_gate_gen_chk #(.PHASE_W(PHASE_W), .N_ANG(N_ANG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .leg1_hi   (leg1_hi_o),
  .leg1_lo   (leg1_lo_o),
  .leg2_hi   (leg2_hi_o),
  .leg2_lo   (leg2_lo_o),
  .ld_valid  (ld_valid_i),
  .ld_ready  (ld_ready_o),
  .ld_last   (ld_last_i),
  .tbl_err   (tbl_err_o),
  .wrap      (wrap),
  .pending   (pending),
  .act_valid (act_valid),
  .active    (active_tbl)
);

// File: tb/sheg_gate_gen_bench.sv
`timescale 1ns/1ps
module sheg_gate_gen_bench;
  localparam int NA = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] freq = '0;
  logic        ld_valid = 1'b0;
  logic [15:0] ld_angle = '0;
  logic        ld_last = 1'b0;
  logic        ld_ready, tbl_err;
  logic        l1h, l1l, l2h, l2l;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  sheg_gate_gen u_sheg_gate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_i     (freq),
    .ld_valid_i (ld_valid),
    .ld_ready_o (ld_ready),
    .ld_angle_i (ld_angle),
    .ld_last_i  (ld_last),
    .tbl_err_o  (tbl_err),
    .leg1_hi_o  (l1h),
    .leg1_lo_o  (l1l),
    .leg2_hi_o  (l2h),
    .leg2_lo_o  (l2l)
  );

  typedef struct packed {
    logic [3:0] g;
    logic       rdy;
    logic       err;
    logic       nz;
    logic [3:0] tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state built from the requirements
  logic [15:0] m_phase = '0;
  int          m_sh[NA];
  int          m_act[NA];
  logic        m_act_v = 1'b0, m_pend = 1'b0, m_err = 1'b0, m_ovf = 1'b0;
  logic        m_zsel = 1'b0, m_acc = 1'b0;
  int          m_prev = 0, m_widx = 0;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd6:    return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic int ref_level(input logic [15:0] ph);
    int x, cnt;
    x = ph[14] ? (32'h4000 - int'(ph[13:0])) : int'(ph[13:0]);
    cnt = 0;
    for (int k = 0; k < NA; k++) if (m_act[k] <= x) cnt++;
    if (!m_act_v || (cnt % 2 == 0)) return 0;
    return ph[15] ? -1 : 1;
  endfunction

  function automatic bit sh_ordered();
    for (int k = 0; k < NA; k++) begin
      if (m_sh[k] >= 32'h4000) return 0;
      if (k > 0 && m_sh[k-1] >= m_sh[k]) return 0;
    end
    return 1;
  endfunction

  initial for (int k = 0; k < NA; k++) begin m_sh[k] = 0; m_act[k] = 0; end

  // Driver side of the scoreboard: predict each edge, push expectation
  always @(posedge clk) begin
    if (rst_n) begin : mdl
      logic [16:0] s;
      int          lv;
      logic        swap;
      exp_t        e;
      s    = {1'b0, m_phase} + {1'b0, freq};
      lv   = ref_level(m_phase);
      if (lv == 0 && m_prev != 0) m_zsel = ~m_zsel;
      m_prev = lv;
      e.g  = (lv == 1) ? 4'b1001 : (lv == -1) ? 4'b0110 : (m_zsel ? 4'b1010 : 4'b0101);
      e.nz = (lv != 0);
      if (!m_act_v)         e.tag = 4'd10;
      else if (s[16])       e.tag = 4'd1;
      else if (lv == 0)     e.tag = 4'd6;
      else if (!m_phase[15] && !m_phase[14]) e.tag = 4'd2;
      else if (!m_phase[15]) e.tag = 4'd3;
      else                   e.tag = 4'd4;
      m_acc = ld_valid && !m_pend;
      swap  = s[16] && m_pend;
      if (swap) begin
        for (int k = 0; k < NA; k++) m_act[k] = m_sh[k];
        m_act_v = 1'b1;
        m_pend  = 1'b0;
      end
      if (m_acc) begin
        if (m_widx < NA) m_sh[m_widx] = int'(ld_angle);
        else if (!ld_last) m_ovf = 1'b1;
        if (ld_last) begin
          if (m_widx == NA - 1 && !m_ovf && sh_ordered()) begin
            m_pend = 1'b1; m_err = 1'b0;
          end else begin
            m_err = 1'b1;
          end
          m_widx = 0; m_ovf = 1'b0;
        end else if (m_widx < NA) begin
          m_widx++;
        end
      end
      m_phase = s[15:0];
      e.rdy = !m_pend;
      e.err = m_err;
      exp_q.push_back(e);
    end
  end

  // Monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin : mon
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if ({l1h, l1l, l2h, l2l} !== e.g) begin
        n_bad++;
        $display("FAIL %s%s gates actual=%b expected=%b", tag_name(e.tag),
                 e.nz ? " R5" : "", {l1h, l1l, l2h, l2l}, e.g);
      end
      n_vec++;
      if ($countones({l1h, l1l}) != 1 || $countones({l2h, l2l}) != 1) begin
        n_bad++;
        $display("FAIL R7 leg state actual=%b expected=one per leg", {l1h, l1l, l2h, l2l});
      end
      n_vec++;
      if (ld_ready !== e.rdy) begin
        n_bad++;
        $display("FAIL R9 ld_ready actual=%b expected=%b", ld_ready, e.rdy);
      end
      n_vec++;
      if (tbl_err !== e.err) begin
        n_bad++;
        $display("FAIL R8 tbl_err actual=%b expected=%b", tbl_err, e.err);
      end
    end
  end

  task automatic load(input int a0, a1, a2, a3, a4, a5, input int nb);
    int vals[6];
    vals = '{a0, a1, a2, a3, a4, a5};
    for (int b = 0; b < nb; b++) begin
      ld_valid = 1'b1;
      ld_angle = vals[b][15:0];
      ld_last  = (b == nb - 1);
      do @(negedge clk); while (!m_acc);
    end
    ld_valid = 1'b0;
    ld_last  = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    n_vec++;
    if ({l1h, l1l, l2h, l2l} !== 4'b0101 || ld_ready !== 1'b1 || tbl_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset actual=%b/%b/%b expected=0101/1/0",
               {l1h, l1l, l2h, l2l}, ld_ready, tbl_err);
    end
    freq  = 16'h0100;
    rst_n = 1'b1;
    run(300);                                        // R10 with no table
    load('h0800, 'h1400, 'h2000, 'h2C00, 'h3800, 0, 5);
    run(800);
    load('h0800, 'h2000, 'h1400, 'h2C00, 'h3800, 0, 5);  // R8 out of order
    run(100);
    load('h0800, 'h0800, 'h2000, 'h2C00, 'h3800, 0, 5);  // R8 equal pair
    run(100);
    load('h0800, 'h1400, 'h2000, 'h2C00, 'h4000, 0, 5);  // R8 at quarter edge
    run(100);
    load('h0800, 'h1400, 'h2000, 'h2C00, 0, 0, 4);       // R8 short
    run(100);
    load('h0800, 'h1400, 'h2000, 'h2C00, 'h3000, 'h3800, 6); // R8 long
    run(100);
    freq = 16'h0333;
    run(300);
    load('h0300, 'h0900, 'h1A00, 'h2500, 'h3FFF, 0, 5);
    load('h0100, 'h0200, 'h0300, 'h3000, 'h3F00, 0, 5);  // R9 back-pressure
    run(800);
    freq = 16'h0000;
    run(50);
    freq = 16'h0040;
    run(2100);
    freq = 16'hFFFF;
    run(200);
    summary();
  end
endmodule